// File: doc/BRIEF.md
# Offset-Corrected Charge Accumulator

The block sits behind a sigma-delta style current converter and turns its stream of signed current samples into a running charge count. Each accepted conversion is one of two kinds. Most are ordinary measurements. The converter then supplies a signed current word, and the block corrects it by subtracting the most recently measured converter offset. The corrected value is kept as the latest current reading and is added into a signed, saturating charge accumulator. Every `CAL_PERIOD`-th conversion is instead a calibration slot. The converter reports its own input offset during that slot, so no current is measured. The block captures that word as the new offset, and it corrects the ordinary conversions that follow until the next calibration slot.

The block tells the converter which conversion is next through `cal_slot_o`. A host reads the latest current, the charge and the captured offset through a small register port. The host can also preset or clear the charge. A sleep input freezes all measurement activity and leaves the register port fully usable. A build-time option selects a reduced-resolution converter, in which the two lowest sample bits are discarded.

Top module: `charge_meter_core`

## Requirements
- R1: After reset the latest current, the charge and the offset all read as zero, and `cal_slot_o` is low.
- R2: Conversions are counted from reset. The conversion at 0-based position `CAL_PERIOD-1` within each group of `CAL_PERIOD` accepted conversions is a calibration slot. `cal_slot_o` is high exactly while the next accepted conversion is a calibration slot.
- R3: A calibration conversion loads its sample word into the offset register. It leaves both the latest current and the charge unchanged.
- R4: An ordinary conversion with sample `d` sets the latest current to `d - offset`, a 17-bit signed value. It also adds that value to the charge on the same clock edge.
- R5: The offset is zero until the first calibration slot. After that it corrects every ordinary conversion until the next calibration slot. A constant converter offset therefore cancels exactly in the charge.
- R6: The charge is a 32-bit signed count that saturates at 0x7FFFFFFF and 0x80000000 and never wraps.
- R7: A host write to address 1 loads the charge. When a write coincides with an accumulation on the same edge, the written value is kept.
- R8: While `sleep_i` is high, `smp_valid_i` is ignored: the current, the charge, the offset and the slot position all stay put. Host reads and writes still work.
- R9: The register read data is combinational from `reg_addr_i`. Address 0 gives the latest current, sign-extended. Address 1 gives the charge. Address 2 gives the offset, sign-extended. Address 3 reads zero. Writes to addresses 0, 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Freezes measurement and accumulation |
| smp_valid_i | input | 1 | One conversion result is present this cycle |
| smp_data_i | input | 16 | Signed conversion word (sign plus 15 bits) |
| cal_slot_o | output | 1 | The next conversion is a calibration slot |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |

## Verification
The first pattern is a flat run of identical samples before any calibration. It shows that the offset starts at zero and that the calibration slot falls at the right position. The second pattern adds a constant offset to a varying, sign-alternating current. Once a calibration slot has captured that offset, the charge must equal the sum of the true currents exactly, which separates a correct subtraction from an off-by-one in the slot window. Presets near both rails are followed by large samples to show clamping instead of wrap-around. A write is made on the same edge as a sample to expose priority. Sleep pulses and writes to read-only addresses show that those inputs leave the observable state untouched.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      RSEL_CURRENT = 2'd0,
      RSEL_CHARGE  = 2'd1,
      RSEL_OFFSET  = 2'd2,
      RSEL_SPARE   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/cmc_slot_sched.sv
module cmc_slot_sched #(
   parameter int unsigned CAL_PERIOD = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   output logic cal_slot_o
);
   localparam int unsigned CNT_W = $clog2(CAL_PERIOD);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (CAL_PERIOD >= 2) else $error("CAL_PERIOD must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step_i) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cal_slot_o = (cnt_q == LAST);

   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R2
   AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && cal_slot_o) |=> (cnt_q == '0)); // R2
   AST_SLOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/cmc_offset_corr.sv
module cmc_offset_corr #(
   parameter int unsigned SAMPLE_W    = 16,
   parameter bit          REDUCED_RES = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       step_i,
   input  logic                       cal_i,
   input  logic [SAMPLE_W-1:0]        data_i,
   output logic [SAMPLE_W-1:0]        ofs_o,
   output logic signed [SAMPLE_W:0]   corr_o,
   output logic signed [SAMPLE_W:0]   cur_o,
   output logic                       add_o
);
   localparam int unsigned DROP   = REDUCED_RES ? 2 : 0;
   localparam int unsigned CORR_W = SAMPLE_W + 1;

   logic [SAMPLE_W-1:0]      data_use;
   logic [SAMPLE_W-1:0]      ofs_q;
   logic signed [CORR_W-1:0] cur_q;
   logic signed [CORR_W-1:0] data_ext;
   logic signed [CORR_W-1:0] ofs_ext;

   initial begin
      assert (SAMPLE_W > DROP + 1) else $error("SAMPLE_W too small for resolution mode");
   end

   generate
      if (DROP > 0) begin : g_reduced
         assign data_use = {data_i[SAMPLE_W-1:DROP], {DROP{1'b0}}};
      end else begin : g_full
         assign data_use = data_i;
      end
   endgenerate

   assign data_ext = signed'({data_use[SAMPLE_W-1], data_use});
   assign ofs_ext  = signed'({ofs_q[SAMPLE_W-1], ofs_q});
   assign corr_o   = data_ext - ofs_ext;
   assign add_o    = step_i && !cal_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= '0;
         cur_q <= '0;
      end else if (step_i) begin
         if (cal_i) ofs_q <= data_use;
         else       cur_q <= corr_o;
      end
   end

   assign ofs_o = ofs_q;
   assign cur_o = cur_q;

   AST_CAL_KEEPS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && cal_i) |=> $stable(cur_q)); // R3
   AST_OFS_ONLY_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_i && cal_i) |=> $stable(ofs_q)); // R5
   AST_CUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(cur_q)); // R8

endmodule

// File: rtl/cmc_sat_acc.sv
module cmc_sat_acc #(
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned CORR_W = 17
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     add_i,
   input  logic signed [CORR_W-1:0] corr_i,
   input  logic                     wr_i,
   input  logic [ACC_W-1:0]         wdata_i,
   output logic [ACC_W-1:0]         acc_o
);
   localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;
   logic [ACC_W-1:0] sum_sat;

   initial begin
      assert (ACC_W > CORR_W) else $error("ACC_W must exceed corrected width");
   end

   assign sum = {{(ACC_W+1-CORR_W){corr_i[CORR_W-1]}}, corr_i} + {acc_q[ACC_W-1], acc_q};

   always_comb begin
      if (sum[ACC_W] != sum[ACC_W-1]) sum_sat = sum[ACC_W] ? ACC_MIN : ACC_MAX;
      else                            sum_sat = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (wr_i)  acc_q <= wdata_i;
      else if (add_i) acc_q <= sum_sat;
   end

   assign acc_o = acc_q;

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (acc_q == $past(wdata_i))); // R7
   AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && !add_i) |=> $stable(acc_q)); // R4
   AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (add_i && !wr_i && acc_q == ACC_MAX && !corr_i[CORR_W-1]) |=> (acc_q == ACC_MAX)); // R6
   AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (add_i && !wr_i && acc_q == ACC_MIN && corr_i[CORR_W-1]) |=> (acc_q == ACC_MIN)); // R6

endmodule

// File: rtl/charge_meter_core.sv
module charge_meter_core #(
   parameter int unsigned SAMPLE_W    = 16,
   parameter int unsigned ACC_W       = 32,
   parameter int unsigned CAL_PERIOD  = 1024,
   parameter bit          REDUCED_RES = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep_i,
   input  logic                smp_valid_i,
   input  logic [SAMPLE_W-1:0] smp_data_i,
   output logic                cal_slot_o,
   input  logic [1:0]          reg_addr_i,
   input  logic                reg_wr_i,
   input  logic [ACC_W-1:0]    reg_wdata_i,
   output logic [ACC_W-1:0]    reg_rdata_o
);
   import cmc_pkg::*;

   localparam int unsigned CORR_W = SAMPLE_W + 1;

   logic                     step;
   logic                     add;
   logic                     acc_wr;
   logic [SAMPLE_W-1:0]      ofs;
   logic signed [CORR_W-1:0] corr;
   logic signed [CORR_W-1:0] cur;
   logic [ACC_W-1:0]         acc;
   reg_sel_e                 rsel;

   initial begin
      assert (ACC_W >= CORR_W) else $error("register width below corrected width");
   end

   assign step   = smp_valid_i && !sleep_i;
   assign rsel   = reg_sel_e'(reg_addr_i);
   assign acc_wr = reg_wr_i && (rsel == RSEL_CHARGE);

   cmc_slot_sched #(.CAL_PERIOD(CAL_PERIOD)) i_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step),
      .cal_slot_o(cal_slot_o)
   );

   cmc_offset_corr #(.SAMPLE_W(SAMPLE_W), .REDUCED_RES(REDUCED_RES)) i_corr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .cal_i  (cal_slot_o),
      .data_i (smp_data_i),
      .ofs_o  (ofs),
      .corr_o (corr),
      .cur_o  (cur),
      .add_o  (add)
   );

   cmc_sat_acc #(.ACC_W(ACC_W), .CORR_W(CORR_W)) i_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .add_i  (add),
      .corr_i (corr),
      .wr_i   (acc_wr),
      .wdata_i(reg_wdata_i),
      .acc_o  (acc)
   );

   always_comb begin
      case (rsel)
         RSEL_CURRENT: reg_rdata_o = {{(ACC_W-CORR_W){cur[CORR_W-1]}}, cur};
         RSEL_CHARGE:  reg_rdata_o = acc;
         RSEL_OFFSET:  reg_rdata_o = {{(ACC_W-SAMPLE_W){ofs[SAMPLE_W-1]}}, ofs};
         default:      reg_rdata_o = '0;
      endcase
   end

   AST_SLEEP_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && !acc_wr) |=> $stable(acc)); // R8
   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsel == RSEL_SPARE) |-> (reg_rdata_o == '0)); // R9

endmodule

// File: tb/test_charge_meter_core.sv
`timescale 1ns/100ps
module test_charge_meter_core;
   localparam int CAL = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_i = 1'b0;
   logic        smp_valid_i = 1'b0;
   logic [15:0] smp_data_i = '0;
   logic        cal_slot_o;
   logic [1:0]  reg_addr_i = '0;
   logic        reg_wr_i = 1'b0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;

   always #2 clk = ~clk;

   charge_meter_core i_charge_meter_core (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
      .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
      .cal_slot_o(cal_slot_o), .reg_addr_i(reg_addr_i),
      .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
   );

   typedef struct {
      logic [31:0] cur;
      logic [31:0] acc;
      logic [31:0] ofs;
      string       req;
   } exp_t;

   exp_t   sb[$];
   int     checks = 0;
   int     failures = 0;
   longint cur_m = 0, acc_m = 0, ofs_m = 0;
   int     cnt_m = 0;
   logic [31:0] rv;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr_i = a;
      #0.3;
      v = reg_rdata_o;
   endtask

   function automatic longint sat(input longint v);
      if (v > 64'sd2147483647) return 64'sd2147483647;
      if (v < -64'sd2147483648) return -64'sd2147483648;
      return v;
   endfunction

   // driver: one conversion, optional same-edge charge write; pushes expectation
   task automatic conv(input int data, input bit wr, input int wdata, input string req);
      exp_t e;
      bit   add;
      @(negedge clk);
      smp_valid_i = 1'b1;
      smp_data_i  = 16'(data);
      reg_wr_i    = wr;
      reg_addr_i  = 2'd1;
      reg_wdata_i = wdata;
      add = 1'b0;
      if (!sleep_i) begin
         if (cnt_m == CAL - 1) begin
            ofs_m = data; cnt_m = 0;
         end else begin
            cur_m = longint'(data) - ofs_m; add = 1'b1; cnt_m++;
         end
      end
      if (wr)       acc_m = wdata;
      else if (add) acc_m = sat(acc_m + cur_m);
      @(posedge clk);
      #0.5;
      smp_valid_i = 1'b0;
      reg_wr_i    = 1'b0;
      e.cur = 32'(cur_m); e.acc = 32'(acc_m); e.ofs = 32'(ofs_m); e.req = req;
      sb.push_back(e);
   endtask

   // monitor: pop the oldest expectation and compare it with the register view
   task automatic mon();
      exp_t e;
      logic [31:0] c, a, o;
      e = sb.pop_front();
      rd(2'd0, c); rd(2'd1, a); rd(2'd2, o);
      chk({e.req, " current"}, c, e.cur);
      chk({e.req, " charge"}, a, e.acc);
      chk({e.req, " offset"}, o, e.ofs);
   endtask

   task automatic host_wr(input logic [1:0] a, input int v);
      @(negedge clk);
      reg_addr_i = a; reg_wr_i = 1'b1; reg_wdata_i = v;
      if (a == 2'd1) acc_m = v;
      @(posedge clk);
      #0.5;
      reg_wr_i = 1'b0;
   endtask

   initial begin : watchdog
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
   end

   initial begin : main
      int tsum;
      repeat (3) @(posedge clk);
      #0.5;
      // R1 reset state
      rd(2'd0, rv); chk("R1 current", rv, 32'd0);
      rd(2'd1, rv); chk("R1 charge", rv, 32'd0);
      rd(2'd2, rv); chk("R1 offset", rv, 32'd0);
      chk("R1 cal_slot", {31'd0, cal_slot_o}, 32'd0);
      rst_n = 1'b1;

      // R5 offset zero before first calibration; R4 flat samples
      for (int i = 0; i < CAL - 1; i++) begin
         conv(100, 1'b0, 0, "R5");
         if (i == CAL - 3) chk("R2 slot low before position", {31'd0, cal_slot_o}, 32'd0);
         if (i < 4 || i == CAL - 2) mon(); else void'(sb.pop_front());
      end
      chk("R2 slot high at position CAL-1", {31'd0, cal_slot_o}, 32'd1);

      // R3 calibration captures offset, holds current and charge
      conv(37, 1'b0, 0, "R3");
      mon();
      chk("R2 slot low after calibration", {31'd0, cal_slot_o}, 32'd0);

      // R7 clear charge, then R5 constant offset cancels exactly
      host_wr(2'd1, 0);
      tsum = 0;
      for (int i = 0; i < CAL - 1; i++) begin
         int t;
         t = ((i % 7) - 3) * 50;
         tsum += t;
         conv(t + 37, 1'b0, 0, "R4");
         mon();
      end
      rd(2'd1, rv); chk("R5 offset cancelled in charge", rv, 32'(tsum));
      chk("R2 slot high again", {31'd0, cal_slot_o}, 32'd1);

      // negative offset capture
      conv(-5, 1'b0, 0, "R3");
      mon();

      // R8 sleep: valid ignored, host port alive
      sleep_i = 1'b1;
      conv(900, 1'b0, 0, "R8");
      mon();
      chk("R8 slot position frozen", {31'd0, cal_slot_o}, 32'd0);
      host_wr(2'd1, 1234);
      rd(2'd1, rv); chk("R8 write during sleep", rv, 32'd1234);
      sleep_i = 1'b0;
      conv(10, 1'b0, 0, "R8 wake");
      mon();

      // R6 saturation at both rails
      host_wr(2'd1, 32'h7FFF_FFF0);
      conv(1000, 1'b0, 0, "R6 high rail");
      mon();
      conv(2000, 1'b0, 0, "R6 stays high");
      mon();
      host_wr(2'd1, 32'h8000_0010);
      conv(-1000, 1'b0, 0, "R6 low rail");
      mon();

      // R7 write wins over same-edge accumulation
      conv(500, 1'b1, 5, "R7");
      mon();

      // R9 writes to other addresses ignored, spare reads zero
      host_wr(2'd0, 32'h1111_1111);
      host_wr(2'd2, 32'h2222_2222);
      host_wr(2'd3, 32'h3333_3333);
      rd(2'd0, rv); chk("R9 current unwritten", rv, 32'(cur_m));
      rd(2'd2, rv); chk("R9 offset unwritten", rv, 32'(ofs_m));
      rd(2'd3, rv); chk("R9 spare reads zero", rv, 32'd0);
      rd(2'd1, rv); chk("R9 charge untouched", rv, 32'(acc_m));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule